// File: doc/BRIEF.md
# Strided DMA Address Generator

This block produces the byte addresses for one side of a DMA transfer, either the read side or the write side. A single load strobe captures a start address, a total byte count, a per-side configuration word and a stride-enable flag. The block then offers one beat at a time on a valid/ready handshake. Each beat carries an address and the number of bytes in that beat. The beat that uses up the byte count is flagged as the last one. Moving the data, running the bus protocol and parsing descriptors are left to neighbouring blocks.

The configuration word selects the bytes per transfer and one of four movement modes: rising, falling, fixed, or rising with a burst hint. The word also holds a block length and a stride. When stride is enabled, the address walks upward through a block of fixed length. It then restarts at the start of that block plus the stride, which begins the next block. This serves two-dimensional buffers such as image lines or interleaved channels. A load while a transfer is in progress abandons that transfer and starts the new one.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `beat_valid_o` and `done_o` are low.
- R2: Configuration word bits 31:30 give the transfer size: code 0, 1, 2, 3 means 1, 2, 4, 8 bytes per beat. A beat that is not shortened reports that many bytes on `beat_bytes_o`. A valid beat never reports 0 bytes or more than 8.
- R3: With stride off and movement code 0 (bits 29:28), each accepted beat raises the next address by the transfer size.
- R4: With stride off and movement code 1, each accepted beat lowers the next address by the transfer size, wrapping modulo 2^ADDR_W.
- R5: With stride off and movement code 2, every beat carries the start address.
- R6: Movement code 3 advances the address like code 0, and `beat_burst_o` is high on every beat of the transfer. For the other codes it is low.
- R7: With stride on, the address rises by the transfer size within a block of N beats, where N is bits 27:14 and 0 counts as 1. After the N-th beat the next address is that block's start address plus the stride (bits 13:0), in bytes. The movement code then affects only the burst hint.
- R8: With stride off, the block-length and stride fields have no effect on the addresses.
- R9: `beat_last_o` is high on exactly the beat that brings the remaining count to zero. When fewer bytes remain than the transfer size, that beat reports only the remaining bytes.
- R10: A load with a byte count of zero produces no beat, and `done_o` is high in the next cycle.
- R11: `done_o` rises in the cycle after the last beat is accepted. It stays high, with `beat_valid_o` low, until the next load with a nonzero count.
- R12: While `beat_valid_o` is high and `beat_ready_i` is low, the address, byte count and last flag hold their values.
- R13: A load has priority over acceptance. A beat presented in the load cycle is discarded, and the first beat afterwards belongs to the new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe: captures the four ld_* inputs |
| ld_base_i | input | ADDR_W | Start address |
| ld_count_i | input | CNT_W | Total byte count |
| ld_side_word_i | input | 32 | Size [31:30], movement [29:28], block length [27:14], stride [13:0] |
| ld_stride_en_i | input | 1 | Selects stride mode for this transfer |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | The consumer takes the offered beat |
| beat_addr_o | output | ADDR_W | Byte address of the beat |
| beat_bytes_o | output | 4 | Bytes in the beat, 1 to 8 |
| beat_last_o | output | 1 | Final beat of the transfer |
| beat_burst_o | output | 1 | Burst hint for the beat |
| done_o | output | 1 | Transfer finished; stays high until the next nonzero load |

## Verification
The bench builds the block with ADDR_W = 16 and CNT_W = 12. The 16-bit address lets a falling transfer cross below zero within a few beats, so the modulo wrap is checked directly. The small count width keeps each case short, so every movement mode, stride with zero and nonzero block lengths, and shortened final beats all fit in one run. Ready is driven always high, from a pseudo-random pattern, or held low. Together these cover stalls, back-to-back acceptance and a reload in the middle of a transfer.

// File: rtl/sag_pkg.sv
package sag_pkg;

    localparam int FIELD_W = 14;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        MV_INC   = 2'd0,
        MV_DEC   = 2'd1,
        MV_HOLD  = 2'd2,
        MV_BURST = 2'd3
    } move_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    // Per-side configuration word, most significant field first.
    typedef struct packed {
        xfer_size_e           size;
        move_e                move;
        logic [FIELD_W-1:0]   blk_len;
        logic [FIELD_W-1:0]   stride;
    } side_word_t;

    function automatic logic [3:0] size_to_bytes(input xfer_size_e s);
        return 4'd1 << s;
    endfunction

endpackage

// File: rtl/sag_ctrl.sv
module sag_ctrl
    import sag_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic [3:0]       size_bytes,
    input  logic             accept,
    output logic             valid,
    output logic             done,
    output logic [3:0]       beat_bytes,
    output logic             last
);

    localparam int PAD_W = CNT_W - 4;

    run_state_e       state_q;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] size_ext;
    logic [CNT_W-1:0] taken_ext;
    logic             short_beat;

    always_comb begin
        size_ext   = {{PAD_W{1'b0}}, size_bytes};
        short_beat = remain_q < size_ext;
        beat_bytes = short_beat ? remain_q[3:0] : size_bytes;
        last       = remain_q <= size_ext;
        taken_ext  = {{PAD_W{1'b0}}, beat_bytes};
        valid      = (state_q == ST_RUN);
        done       = (state_q == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_count;
            state_q  <= (load_count == '0) ? ST_DONE : ST_RUN;
        end else if (state_q == ST_RUN && accept) begin
            remain_q <= remain_q - taken_ext;
            if (last) begin
                state_q <= ST_DONE;
            end
        end
    end

endmodule

// File: rtl/sag_step.sv
module sag_step
    import sag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ADDR_W-1:0]  load_base,
    input  logic               advance,
    input  logic [3:0]         size_bytes,
    input  move_e              mode,
    input  logic               stride_en,
    input  logic [FIELD_W-1:0] blk_len,
    input  logic [FIELD_W-1:0] stride,
    output logic [ADDR_W-1:0]  addr
);

    localparam int STEP_PAD   = ADDR_W - 4;
    localparam int STRIDE_PAD = ADDR_W - FIELD_W;

    logic [ADDR_W-1:0]  addr_q, addr_nx;
    logic [ADDR_W-1:0]  start_q, start_nx;
    logic [FIELD_W-1:0] cnt_q, cnt_nx;
    logic [ADDR_W-1:0]  step_amt;
    logic [ADDR_W-1:0]  stride_amt;
    logic [FIELD_W-1:0] blk_eff;
    logic               block_full;

    always_comb begin
        step_amt   = {{STEP_PAD{1'b0}}, size_bytes};
        stride_amt = {{STRIDE_PAD{1'b0}}, stride};
        blk_eff    = (blk_len == '0) ? FIELD_W'(1) : blk_len;
        block_full = ({1'b0, cnt_q} + (FIELD_W+1)'(1)) >= {1'b0, blk_eff};
        addr_nx    = addr_q;
        start_nx   = start_q;
        cnt_nx     = cnt_q;
        if (stride_en) begin
            if (block_full) begin
                addr_nx  = start_q + stride_amt;
                start_nx = start_q + stride_amt;
                cnt_nx   = '0;
            end else begin
                addr_nx  = addr_q + step_amt;
                cnt_nx   = cnt_q + FIELD_W'(1);
            end
        end else begin
            unique case (mode)
                MV_INC, MV_BURST: addr_nx = addr_q + step_amt;
                MV_DEC:           addr_nx = addr_q - step_amt;
                MV_HOLD:          addr_nx = addr_q;
                default:          addr_nx = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            addr_q  <= load_base;
            start_q <= load_base;
            cnt_q   <= '0;
        end else if (advance) begin
            addr_q  <= addr_nx;
            start_q <= start_nx;
            cnt_q   <= cnt_nx;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
    import sag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] ld_base_i,
    input  logic [CNT_W-1:0]  ld_count_i,
    input  logic [31:0]       ld_side_word_i,
    input  logic              ld_stride_en_i,
    output logic              beat_valid_o,
    input  logic              beat_ready_i,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic [3:0]        beat_bytes_o,
    output logic              beat_last_o,
    output logic              beat_burst_o,
    output logic              done_o
);

    side_word_t cfg_q;
    logic       stride_en_q;
    logic [3:0] size_bytes;
    logic       accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= '0;
            stride_en_q <= 1'b0;
        end else if (load_i) begin
            cfg_q       <= side_word_t'(ld_side_word_i);
            stride_en_q <= ld_stride_en_i;
        end
    end

    assign size_bytes = size_to_bytes(cfg_q.size);
    assign accept     = beat_valid_o && beat_ready_i && !load_i;

    sag_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .load       (load_i),
        .load_count (ld_count_i),
        .size_bytes (size_bytes),
        .accept     (accept),
        .valid      (beat_valid_o),
        .done       (done_o),
        .beat_bytes (beat_bytes_o),
        .last       (beat_last_o)
    );

    sag_step #(.ADDR_W(ADDR_W)) step_i (
        .clk        (clk),
        .rst        (rst),
        .load       (load_i),
        .load_base  (ld_base_i),
        .advance    (accept),
        .size_bytes (size_bytes),
        .mode       (cfg_q.move),
        .stride_en  (stride_en_q),
        .blk_len    (cfg_q.blk_len),
        .stride     (cfg_q.stride),
        .addr       (beat_addr_o)
    );

    assign beat_burst_o = beat_valid_o && (cfg_q.move == MV_BURST);

endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [CNT_W-1:0]  ld_count,
    input logic              valid,
    input logic              ready,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        bytes,
    input logic              last,
    input logic              done,
    input logic [1:0]        mv,
    input logic              sen
);

    logic step_ok;
    assign step_ok = valid && ready && !load && !last && !sen;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !valid && !done); // R1

    AST_BYTES_BOUND: assert property (@(posedge clk) disable iff (rst)
        valid |-> (bytes != 4'd0) && (bytes <= 4'd8)); // R2

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        step_ok && mv == 2'd1 |=>
        addr == $past(addr) - {{(ADDR_W-4){1'b0}}, $past(bytes)}); // R4

    AST_STATIC_ADDR: assert property (@(posedge clk) disable iff (rst)
        step_ok && mv == 2'd2 |=> addr == $past(addr)); // R5

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        step_ok && mv == 2'd3 |=>
        addr == $past(addr) + {{(ADDR_W-4){1'b0}}, $past(bytes)}); // R6

    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (rst)
        load && ld_count == '0 |=> done && !valid); // R10

    AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
        valid && ready && last && !load |=> done && !valid); // R11

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !valid); // R11

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        valid && !ready && !load |=>
        valid && $stable(addr) && $stable(bytes) && $stable(last)); // R12

endmodule

bind stride_addr_gen sag_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load_i),
    .ld_count (ld_count_i),
    .valid    (beat_valid_o),
    .ready    (beat_ready_i),
    .addr     (beat_addr_o),
    .bytes    (beat_bytes_o),
    .last     (beat_last_o),
    .done     (done_o),
    .mv       (cfg_q.move),
    .sen      (stride_en_q)
);

// File: tb/stride_addr_gen_tb_top.sv
module stride_addr_gen_tb_top;

    localparam int AW = 16;
    localparam int CW = 12;

    typedef struct {
        logic [AW-1:0] a;
        logic [3:0]    b;
        logic          l;
        logic          u;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [AW-1:0] ld_base_i = '0;
    logic [CW-1:0] ld_count_i = '0;
    logic [31:0]   ld_side_word_i = '0;
    logic          ld_stride_en_i = 1'b0;
    logic          beat_valid_o;
    logic          beat_ready_i = 1'b0;
    logic [AW-1:0] beat_addr_o;
    logic [3:0]    beat_bytes_o;
    logic          beat_last_o;
    logic          beat_burst_o;
    logic          done_o;

    int     n_tests = 0;
    int     n_fail  = 0;
    int     cyc     = 0;
    int     rdy_mode = 0;
    logic   in_reset = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    string  cur_tag = "R3";
    exp_t   q[$];

    always #5 clk = ~clk;

    stride_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .load_i         (load_i),
        .ld_base_i      (ld_base_i),
        .ld_count_i     (ld_count_i),
        .ld_side_word_i (ld_side_word_i),
        .ld_stride_en_i (ld_stride_en_i),
        .beat_valid_o   (beat_valid_o),
        .beat_ready_i   (beat_ready_i),
        .beat_addr_o    (beat_addr_o),
        .beat_bytes_o   (beat_bytes_o),
        .beat_last_o    (beat_last_o),
        .beat_burst_o   (beat_burst_o),
        .done_o         (done_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    // Ready driver: 0 always ready, 1 pseudo-random, 2 never ready.
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0:       beat_ready_i <= 1'b1;
            1:       beat_ready_i <= lfsr[3];
            default: beat_ready_i <= 1'b0;
        endcase
    end

    // Monitor: compares every accepted beat against the scoreboard.
    always begin
        @(negedge clk);
        #3;
        if (!in_reset && beat_valid_o && beat_ready_i && !load_i) begin
            n_tests = n_tests + 1;
            if (q.size() == 0) begin
                n_fail = n_fail + 1;
                $display("FAIL %s unexpected beat: actual addr=%h bytes=%0d expected none",
                         cur_tag, beat_addr_o, beat_bytes_o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (beat_addr_o !== e.a || beat_bytes_o !== e.b ||
                    beat_last_o !== e.l || beat_burst_o !== e.u) begin
                    n_fail = n_fail + 1;
                    $display("FAIL %s beat: actual addr=%h bytes=%0d last=%b burst=%b expected addr=%h bytes=%0d last=%b burst=%b",
                             cur_tag, beat_addr_o, beat_bytes_o, beat_last_o, beat_burst_o,
                             e.a, e.b, e.l, e.u);
                end
            end
        end
    end

    function automatic logic [31:0] mk_word(input int sz, input int mv,
                                            input int bk, input int st);
        return {sz[1:0], mv[1:0], bk[13:0], st[13:0]};
    endfunction

    // Expected beats from the requirements (R2..R9).
    task automatic build_expect(input logic [AW-1:0] base, input int count,
                                input logic [31:0] w, input logic sen);
        int            sz;
        int            rem;
        int            blk;
        int            inblk;
        logic [AW-1:0] a;
        logic [AW-1:0] bstart;
        exp_t          e;
        sz     = 1 << w[31:30];
        blk    = (w[27:14] == 0) ? 1 : int'(w[27:14]);
        rem    = count;
        a      = base;
        bstart = base;
        inblk  = 0;
        while (rem > 0) begin
            e.a = a;
            e.b = 4'((rem < sz) ? rem : sz);
            e.l = (rem <= sz);
            e.u = (w[29:28] == 2'd3);
            q.push_back(e);
            rem = rem - int'(e.b);
            if (sen) begin
                inblk = inblk + 1;
                if (inblk == blk) begin
                    bstart = bstart + AW'(w[13:0]);
                    a      = bstart;
                    inblk  = 0;
                end else begin
                    a = a + AW'(sz);
                end
            end else begin
                case (w[29:28])
                    2'd1:    a = a - AW'(sz);
                    2'd2:    a = a;
                    default: a = a + AW'(sz);
                endcase
            end
        end
    endtask

    task automatic start_load(input string tag, input logic [AW-1:0] base,
                              input int count, input logic [31:0] w, input logic sen);
        @(negedge clk);
        q.delete();
        cur_tag = tag;
        build_expect(base, count, w, sen);
        ld_base_i      = base;
        ld_count_i     = CW'(count);
        ld_side_word_i = w;
        ld_stride_en_i = sen;
        load_i         = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            #3;
            n = n + 1;
        end while (!done_o && n < 3000);
        n_tests = n_tests + 1;
        if (!done_o || beat_valid_o || q.size() != 0) begin
            n_fail = n_fail + 1;
            $display("FAIL %s R11 end: actual done=%b valid=%b left=%0d expected done=1 valid=0 left=0",
                     tag, done_o, beat_valid_o, q.size());
        end
    endtask

    task automatic run_case(input string tag, input logic [AW-1:0] base,
                            input int count, input logic [31:0] w, input logic sen);
        start_load(tag, base, count, w, sen);
        wait_done(tag);
    endtask

    initial begin
        logic [AW-1:0] a0;
        logic [3:0]    b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        in_reset = 1'b0;
        // R1: reset state
        n_tests = n_tests + 1;
        if (beat_valid_o !== 1'b0 || done_o !== 1'b0) begin
            n_fail = n_fail + 1;
            $display("FAIL R1 reset: actual valid=%b done=%b expected 0 0", beat_valid_o, done_o);
        end

        rdy_mode = 0;
        run_case("R3", 16'h1000, 16, mk_word(2, 0, 0, 0), 1'b0);
        run_case("R2", 16'h0300, 3,  mk_word(0, 0, 0, 0), 1'b0);
        run_case("R2", 16'h0400, 6,  mk_word(1, 0, 0, 0), 1'b0);
        run_case("R2", 16'h0500, 24, mk_word(3, 0, 0, 0), 1'b0);
        run_case("R4", 16'h0006, 10, mk_word(1, 1, 0, 0), 1'b0);
        rdy_mode = 1;
        run_case("R5", 16'h0A00, 12, mk_word(2, 2, 0, 0), 1'b0);
        run_case("R6", 16'h0B00, 20, mk_word(3, 3, 0, 0), 1'b0);
        run_case("R7", 16'h0100, 40, mk_word(2, 1, 3, 16'h40), 1'b1);
        rdy_mode = 0;
        run_case("R7", 16'h0200, 6,  mk_word(1, 3, 0, 16'h10), 1'b1);
        run_case("R8", 16'h0600, 16, mk_word(2, 0, 3, 16'h100), 1'b0);
        run_case("R9", 16'h0700, 7,  mk_word(3, 0, 0, 0), 1'b0);
        run_case("R9", 16'h0710, 11, mk_word(2, 1, 0, 0), 1'b0);

        // R10: zero count gives done at once and no beat
        start_load("R10", 16'h0800, 0, mk_word(2, 0, 0, 0), 1'b0);
        #3;
        n_tests = n_tests + 1;
        if (done_o !== 1'b1 || beat_valid_o !== 1'b0) begin
            n_fail = n_fail + 1;
            $display("FAIL R10 zero count: actual done=%b valid=%b expected 1 0", done_o, beat_valid_o);
        end
        repeat (3) @(negedge clk);

        // R12: stalled beat holds
        rdy_mode = 2;
        start_load("R12", 16'h0C00, 12, mk_word(2, 0, 0, 0), 1'b0);
        @(negedge clk);
        #3;
        a0 = beat_addr_o;
        b0 = beat_bytes_o;
        repeat (4) @(negedge clk);
        #3;
        n_tests = n_tests + 1;
        if (beat_valid_o !== 1'b1 || beat_addr_o !== a0 || beat_bytes_o !== b0) begin
            n_fail = n_fail + 1;
            $display("FAIL R12 stall: actual valid=%b addr=%h bytes=%0d expected valid=1 addr=%h bytes=%0d",
                     beat_valid_o, beat_addr_o, beat_bytes_o, a0, b0);
        end
        rdy_mode = 1;
        wait_done("R12");

        // R13: reload in the middle of a transfer
        rdy_mode = 0;
        start_load("R13", 16'h0D00, 64, mk_word(0, 0, 0, 0), 1'b0);
        repeat (5) @(negedge clk);
        run_case("R13", 16'h0E00, 8, mk_word(1, 1, 0, 0), 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule